// File: doc/BRIEF.md
# Serial Flash Configuration Loader

This block is the master side of a serial-flash boot path. After reset it waits for the active-low configuration request input to be released. It then selects the flash and sends a read instruction with a fixed start address. Next it clocks in a parameterized number of image bits and hands each completed byte to the configuration target with a single-cycle strobe. The block generates the serial clock itself by dividing the system clock, and the flash only answers on the data line.

Once the image has been streamed, the block watches the target's completion input. If completion arrives while bits are still outstanding, or fails to arrive within a bounded window afterwards, the load is failed: the active-low status output is pulled low for a fixed time, a retry counter advances, and the whole sequence starts again. An image that reads back entirely as ones is an erased part and is failed in the same way. A good load is followed by a fixed count of serial clock cycles of initialization, after which the user-mode output rises and stays high.

Top module: `as_cfg_master`

## Requirements
- R1: While `cfg_req_n` is low, `cs_n` is high and `user_mode` is low. Driving `cfg_req_n` low in any state returns the block to idle on the next clock without touching `retry_cnt`.
- R2: `sclk` runs continuously at the system clock divided by `CLK_DIV` (even, at least 2), high for `CLK_DIV/2` cycles and low for `CLK_DIV/2` cycles. It idles high in reset.
- R3: A load asserts `cs_n` low on a falling `sclk` edge and presents 32 bits on `mosi`, MSB first: opcode 0x03 in bits 31..24 and `START_ADDR` in bits 23..0. Each bit is valid at the following rising edge, and `mosi` changes only on falling edges.
- R4: The flash drives image bits from the 32nd falling edge on, and each bit is captured on the falling edge after it was launched. Bits are packed MSB first into bytes, and each byte appears on `byte_data` with `byte_valid` high for exactly one clock. A load yields `NBITS/8` bytes, and `cs_n` rises with the last capture.
- R5: If `done_in` is high while the command or data phase is still running, the load fails.
- R6: If `done_in` stays low for `DONE_WAIT` rising `sclk` edges after the last capture, the load fails.
- R7: If every captured bit of the load is 1, the load fails at the last capture, whatever `done_in` does.
- R8: A failed load holds `status_n` low for exactly `ERR_HOLD` clocks with `cs_n` high. It increments `retry_cnt` (saturating at all ones) and then starts a new load at the next falling `sclk` edge.
- R9: After `done_in` is seen high, `user_mode` rises after `INIT_CYC` rising `sclk` edges. It stays high with `cs_n` and `status_n` high until reset or `cfg_req_n` low.
- R10: In reset, `cs_n`, `status_n` and `sclk` are high, and `user_mode`, `byte_valid` and `retry_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_req_n | input | 1 | Active-low hold-off; loading runs only while high |
| done_in | input | 1 | Completion indication from the configuration target |
| miso | input | 1 | Serial data from the flash |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low flash select |
| mosi | output | 1 | Serial instruction and address to the flash |
| status_n | output | 1 | Active-low error indication, low while a retry is pending |
| user_mode | output | 1 | High once initialization has finished |
| retry_cnt | output | RETRY_W | Saturating count of failed loads |
| byte_data | output | 8 | Assembled image byte |
| byte_valid | output | 1 | One-clock strobe qualifying `byte_data` |

## Verification
All outputs are registered or decoded from registered state. A change in `cfg_req_n` is therefore visible one clock later, and an error shows on `status_n` in the same clock in which `cs_n` rises for a blank image. The instruction is compared bit by bit at the flash model's rising edges. Each byte is compared in the clock after its eighth capture. Results that wait on a serial edge (initialization, the missing-completion timeout, the restart) can fall anywhere within one `CLK_DIV` period, so the bench measures them in clock cycles against a window of one serial period plus the register stage. The error pulse width is counted exactly in clocks.

// File: rtl/as_cfg_pkg.sv
package as_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_WAIT,
    ST_INIT,
    ST_USER,
    ST_ERR
  } seq_state_t;

  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam int         CMD_BITS  = 32;

endpackage

// File: rtl/as_cfg_clkdiv.sv
module as_cfg_clkdiv #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic rise_tk,
  output logic fall_tk
);

  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_d;
  logic          wrap;

  always_comb begin
    wrap   = (cnt_q == CW'(HALF - 1));
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    sclk_d = wrap ? ~sclk : sclk;
  end

  // strobes mark the system clock edge at which sclk toggles
  assign rise_tk = wrap & ~sclk;
  assign fall_tk = wrap & sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sclk  <= sclk_d;
    end
  end

endmodule

// File: rtl/as_cfg_shift.sv
module as_cfg_shift
  import as_cfg_pkg::*;
#(
  parameter logic [23:0] START_ADDR = 24'h000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       shift,
  input  logic       capture,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       blank_now
);

  localparam logic [CMD_BITS-1:0] CMD_WORD = {RD_OPCODE, START_ADDR};

  logic [CMD_BITS-2:0] cmd_q, cmd_d;
  logic                mosi_d;
  logic [6:0]          acc_q, acc_d;
  logic [2:0]          bit_q, bit_d;
  logic                ones_q, ones_d;
  logic [7:0]          byte_d;
  logic                valid_d;

  always_comb begin
    cmd_d   = cmd_q;
    mosi_d  = mosi;
    acc_d   = acc_q;
    bit_d   = bit_q;
    ones_d  = ones_q;
    byte_d  = byte_data;
    valid_d = 1'b0;
    if (load) begin
      mosi_d = CMD_WORD[CMD_BITS-1];
      cmd_d  = CMD_WORD[CMD_BITS-2:0];
      bit_d  = '0;
      ones_d = 1'b1;
    end else if (shift) begin
      mosi_d = cmd_q[CMD_BITS-2];
      cmd_d  = {cmd_q[CMD_BITS-3:0], 1'b0};
    end
    if (capture) begin
      acc_d  = {acc_q[5:0], miso};
      bit_d  = bit_q + 1'b1;
      ones_d = ones_q & miso;
      if (bit_q == 3'd7) begin
        byte_d  = {acc_q, miso};
        valid_d = 1'b1;
      end
    end
  end

  // all bits so far were ones, including the one on the line now
  assign blank_now = ones_q & miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      mosi       <= 1'b0;
      acc_q      <= '0;
      bit_q      <= '0;
      ones_q     <= 1'b1;
      byte_data  <= '0;
      byte_valid <= 1'b0;
    end else begin
      cmd_q      <= cmd_d;
      mosi       <= mosi_d;
      acc_q      <= acc_d;
      bit_q      <= bit_d;
      ones_q     <= ones_d;
      byte_data  <= byte_d;
      byte_valid <= valid_d;
    end
  end

endmodule

// File: rtl/as_cfg_seq.sv
module as_cfg_seq
  import as_cfg_pkg::*;
#(
  parameter int NBITS     = 1024,
  parameter int INIT_CYC  = 8,
  parameter int DONE_WAIT = 16,
  parameter int ERR_HOLD  = 32,
  parameter int RETRY_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_req_n,
  input  logic               done_in,
  input  logic               rise_tk,
  input  logic               fall_tk,
  input  logic               blank_now,
  output logic               load,
  output logic               shift,
  output logic               capture,
  output logic               cs_n,
  output logic               status_n,
  output logic               user_mode,
  output logic [RETRY_W-1:0] retry_cnt
);

  localparam int BW    = $clog2(NBITS + 1);
  localparam int TMAX0 = (INIT_CYC > DONE_WAIT) ? INIT_CYC : DONE_WAIT;
  localparam int TMAX  = (TMAX0 > ERR_HOLD) ? TMAX0 : ERR_HOLD;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int CCW   = $clog2(CMD_BITS);

  seq_state_t       state_q, state_d;
  logic [CCW-1:0]   cmd_q, cmd_d;
  logic [BW-1:0]    bits_q, bits_d;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic [RETRY_W-1:0] rty_d;
  logic             go_err;

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    bits_d  = bits_q;
    tmr_d   = tmr_q;
    rty_d   = retry_cnt;
    load    = 1'b0;
    shift   = 1'b0;
    capture = 1'b0;
    go_err  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fall_tk) begin
          state_d = ST_CMD;
          load    = 1'b1;
          cmd_d   = '0;
        end
      end
      ST_CMD: begin
        if (done_in) begin
          go_err = 1'b1;
        end else if (fall_tk) begin
          if (cmd_q == CCW'(CMD_BITS - 1)) begin
            state_d = ST_DATA;
            bits_d  = BW'(NBITS);
          end else begin
            shift = 1'b1;
            cmd_d = cmd_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (done_in) begin
          go_err = 1'b1;
        end else if (fall_tk) begin
          capture = 1'b1;
          bits_d  = bits_q - 1'b1;
          if (bits_q == BW'(1)) begin
            if (blank_now) begin
              go_err = 1'b1;
            end else begin
              state_d = ST_WAIT;
              tmr_d   = TW'(DONE_WAIT);
            end
          end
        end
      end
      ST_WAIT: begin
        if (done_in) begin
          state_d = ST_INIT;
          tmr_d   = TW'(INIT_CYC);
        end else if (rise_tk) begin
          if (tmr_q == TW'(1)) go_err = 1'b1;
          else                 tmr_d  = tmr_q - 1'b1;
        end
      end
      ST_INIT: begin
        if (rise_tk) begin
          if (tmr_q == TW'(1)) state_d = ST_USER;
          else                 tmr_d   = tmr_q - 1'b1;
        end
      end
      ST_USER: ;
      ST_ERR: begin
        if (tmr_q == TW'(1)) state_d = ST_IDLE;
        else                 tmr_d   = tmr_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase

    if (!cfg_req_n) begin
      state_d = ST_IDLE;
      load    = 1'b0;
      shift   = 1'b0;
      capture = 1'b0;
    end else if (go_err) begin
      state_d = ST_ERR;
      tmr_d   = TW'(ERR_HOLD);
      if (retry_cnt != '1) rty_d = retry_cnt + 1'b1;
    end
  end

  assign cs_n      = !((state_q == ST_CMD) || (state_q == ST_DATA));
  assign status_n  = (state_q != ST_ERR);
  assign user_mode = (state_q == ST_USER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cmd_q     <= '0;
      bits_q    <= '0;
      tmr_q     <= '0;
      retry_cnt <= '0;
    end else begin
      state_q   <= state_d;
      cmd_q     <= cmd_d;
      bits_q    <= bits_d;
      tmr_q     <= tmr_d;
      retry_cnt <= rty_d;
    end
  end

endmodule

// File: rtl/as_cfg_master.sv
module as_cfg_master #(
  parameter int          CLK_DIV    = 4,
  parameter int          NBITS      = 1024,
  parameter logic [23:0] START_ADDR = 24'h000000,
  parameter int          INIT_CYC   = 8,
  parameter int          DONE_WAIT  = 16,
  parameter int          ERR_HOLD   = 32,
  parameter int          RETRY_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_req_n,
  input  logic               done_in,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic               status_n,
  output logic               user_mode,
  output logic [RETRY_W-1:0] retry_cnt,
  output logic [7:0]         byte_data,
  output logic               byte_valid
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       rise_tk, fall_tk;
  logic       load, shift, capture, blank_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  as_cfg_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .sclk    (sclk),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  as_cfg_shift #(.START_ADDR(START_ADDR)) u_shift (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load       (load),
    .shift      (shift),
    .capture    (capture),
    .miso       (miso),
    .mosi       (mosi),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .blank_now  (blank_now)
  );

  as_cfg_seq #(
    .NBITS     (NBITS),
    .INIT_CYC  (INIT_CYC),
    .DONE_WAIT (DONE_WAIT),
    .ERR_HOLD  (ERR_HOLD),
    .RETRY_W   (RETRY_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cfg_req_n (cfg_req_n),
    .done_in   (done_in),
    .rise_tk   (rise_tk),
    .fall_tk   (fall_tk),
    .blank_now (blank_now),
    .load      (load),
    .shift     (shift),
    .capture   (capture),
    .cs_n      (cs_n),
    .status_n  (status_n),
    .user_mode (user_mode),
    .retry_cnt (retry_cnt)
  );

endmodule

// File: rtl/as_cfg_master_chk.sv
module as_cfg_master_chk #(
  parameter int RETRY_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_req_n,
  input logic               sclk,
  input logic               cs_n,
  input logic               mosi,
  input logic               status_n,
  input logic               user_mode,
  input logic [RETRY_W-1:0] retry_cnt,
  input logic               byte_valid
);

  // R1
  req_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |=> (cs_n && !user_mode));

  // R3
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $rose(sclk)) |-> $stable(mosi));

  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R8
  err_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_n |-> cs_n);

  // R8
  retry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_n) |-> ((retry_cnt == $past(retry_cnt) + 1'b1) || ($past(retry_cnt) == '1)));

  // R9
  user_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && cfg_req_n) |=> user_mode);

  // R9
  user_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> (cs_n && status_n));

endmodule

bind as_cfg_master as_cfg_master_chk #(.RETRY_W(RETRY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_req_n  (cfg_req_n),
  .sclk       (sclk),
  .cs_n       (cs_n),
  .mosi       (mosi),
  .status_n   (status_n),
  .user_mode  (user_mode),
  .retry_cnt  (retry_cnt),
  .byte_valid (byte_valid)
);

// File: tb/as_cfg_master_bench.sv
`timescale 1ns/1ps
module as_cfg_master_bench;

  localparam int          DIV    = 4;
  localparam int          NBITS  = 64;
  localparam int          NBYTES = NBITS / 8;
  localparam int          INIT   = 5;
  localparam int          DWAIT  = 6;
  localparam int          HOLD   = 12;
  localparam int          RW     = 3;
  localparam logic [23:0] SADDR  = 24'h0001A4;

  logic clk = 1'b0;
  logic rst_n, cfg_req_n;
  logic done_in = 1'b0;
  logic miso = 1'b0;
  logic sclk, cs_n, mosi, status_n, user_mode, byte_valid;
  logic [RW-1:0] retry_cnt;
  logic [7:0] byte_data;

  always #2 clk = ~clk;

  as_cfg_master #(
    .CLK_DIV(DIV), .NBITS(NBITS), .START_ADDR(SADDR), .INIT_CYC(INIT),
    .DONE_WAIT(DWAIT), .ERR_HOLD(HOLD), .RETRY_W(RW)
  ) u_as_cfg_master (
    .clk(clk), .rst_n(rst_n), .cfg_req_n(cfg_req_n), .done_in(done_in),
    .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .status_n(status_n),
    .user_mode(user_mode), .retry_cnt(retry_cnt), .byte_data(byte_data),
    .byte_valid(byte_valid)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic blank = 1'b0;
  logic [7:0] seed = 8'h00;
  int done_mode = 0;   // 0 normal, 1 early, 2 never

  function automatic logic [7:0] flash_byte(input int k);
    if (blank) return 8'hFF;
    return 8'((int'(SADDR[7:0]) + k) * 13) ^ seed;
  endfunction

  // flash model: samples the instruction on rising edges, launches data on falling
  logic [31:0] cmd_rx = '0;
  int rx_bits = 0, tx_idx = 0;
  always @(posedge sclk) begin
    if (cs_n) rx_bits = 0;
    else if (rx_bits < 32) begin
      cmd_rx = {cmd_rx[30:0], mosi};
      rx_bits++;
    end
  end
  always @(negedge sclk) begin
    logic [7:0] b;
    if (cs_n) tx_idx = 0;
    else if (rx_bits == 32) begin
      b = flash_byte(tx_idx / 8);
      #1 miso = b[7 - (tx_idx % 8)];
      tx_idx++;
    end
  end

  // target model: collects bytes, drives completion
  int load_bytes = 0, byte_bad = 0, bad_act = 0, bad_exp = 0;
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      done_in    = 1'b0;
      load_bytes = 0;
    end else begin
      if (cs_prev && !cs_n) begin
        done_in    = 1'b0;
        load_bytes = 0;
      end
      if (byte_valid) begin
        if (byte_data !== flash_byte(load_bytes)) begin
          byte_bad++;
          bad_act = byte_data;
          bad_exp = flash_byte(load_bytes);
        end
        load_bytes++;
        if (done_mode == 0 && load_bytes == NBYTES) done_in = 1'b1;
        if (done_mode == 1 && load_bytes == 1)      done_in = 1'b1;
      end
    end
    cs_prev = cs_n;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // which: 0 cs_n, 1 status_n, 2 user_mode, 3 done_in
  task automatic wait_sig(input int which, input logic val, input int maxc, output int took);
    logic v;
    took = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      case (which)
        0: v = cs_n;
        1: v = status_n;
        2: v = user_mode;
        default: v = done_in;
      endcase
      if (v === val) begin
        took = i;
        break;
      end
    end
  endtask

  task automatic do_reset();
    cfg_req_n = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic good_load(input logic [7:0] s);
    int t1, t2, bad0;
    bit lost;
    do_reset();
    seed = s; blank = 1'b0; done_mode = 0;
    bad0 = byte_bad;
    cfg_req_n = 1'b1;
    wait_sig(3, 1'b1, 3000, t1);
    check(t1 > 0, "R4 completion reached", t1, 1);
    check(load_bytes == NBYTES, "R4 byte count", load_bytes, NBYTES);
    check(byte_bad == bad0, "R4 byte value", bad_act, bad_exp);
    check(cmd_rx == {8'h03, SADDR}, "R3 instruction word", cmd_rx, {8'h03, SADDR});
    check(cs_n == 1'b1, "R4 deselect after load", cs_n, 1);
    wait_sig(2, 1'b1, 200, t2);
    check(t2 >= (INIT - 1) * DIV && t2 <= INIT * DIV + 2, "R9 init length", t2, INIT * DIV);
    check(retry_cnt == 0 && status_n == 1'b1, "R9 clean load", retry_cnt, 0);
    lost = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!user_mode || !cs_n || !status_n) lost = 1'b1;
    end
    check(!lost, "R9 user mode held", lost, 0);
    cfg_req_n = 1'b0;
    @(negedge clk);
    check(user_mode == 1'b0 && cs_n == 1'b1, "R1 request drop leaves user mode", user_mode, 0);
  endtask

  initial begin
    int t, w, tp0, tp1, tp2;
    bit bad;
    rst_n = 1'b0;
    cfg_req_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10
    check(cs_n && status_n && sclk, "R10 reset high outputs", {cs_n, status_n, sclk}, 3'b111);
    check(!user_mode && !byte_valid && retry_cnt == 0, "R10 reset low outputs",
          {user_mode, byte_valid, retry_cnt}, 0);
    rst_n = 1'b1;

    // R1: held request keeps the flash deselected
    bad = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!cs_n || byte_valid || user_mode) bad = 1'b1;
    end
    check(!bad, "R1 hold-off", bad, 0);

    // R2: clock divider period and duty
    @(posedge sclk); tp0 = int'($time);
    @(negedge sclk); tp1 = int'($time);
    @(posedge sclk); tp2 = int'($time);
    check((tp1 - tp0) == 4 * DIV / 2, "R2 high time", (tp1 - tp0) / 4, DIV / 2);
    check((tp2 - tp0) == 4 * DIV, "R2 period", (tp2 - tp0) / 4, DIV);

    // R3 R4 R9: two good loads with different contents
    good_load(8'h00);
    good_load(8'hA5);

    // R5: completion arrives after the first byte
    do_reset();
    done_mode = 1; blank = 1'b0;
    cfg_req_n = 1'b1;
    wait_sig(1, 1'b0, 3000, t);
    check(t > 0 && load_bytes < NBYTES, "R5 early completion fails", load_bytes, 1);
    check(retry_cnt == 1, "R8 retry count after one failure", retry_cnt, 1);
    w = 1; bad = 1'b0;
    while (w < 100) begin
      @(negedge clk);
      if (status_n) break;
      if (!cs_n) bad = 1'b1;
      w++;
    end
    check(w == HOLD, "R8 status low width", w, HOLD);
    check(!bad, "R8 deselect during error", bad, 0);
    wait_sig(0, 1'b0, 2 * DIV, t);
    check(t > 0, "R8 restart after hold", t, DIV);
    cfg_req_n = 1'b0;
    @(negedge clk);
    check(cs_n == 1'b1 && retry_cnt == 1, "R1 abort keeps retry count", retry_cnt, 1);

    // R6: completion never arrives
    do_reset();
    done_mode = 2;
    cfg_req_n = 1'b1;
    wait_sig(0, 1'b0, 100, t);
    wait_sig(0, 1'b1, 3000, t);
    check(load_bytes == NBYTES - 1 || load_bytes == NBYTES, "R6 full load before timeout",
          load_bytes, NBYTES);
    wait_sig(1, 1'b0, 200, t);
    check(t >= (DWAIT - 1) * DIV && t <= DWAIT * DIV + 2, "R6 timeout window", t, DWAIT * DIV);
    check(load_bytes == NBYTES, "R6 bytes delivered", load_bytes, NBYTES);

    // R7: erased image with completion still signalled
    do_reset();
    done_mode = 0; blank = 1'b1;
    cfg_req_n = 1'b1;
    wait_sig(0, 1'b0, 100, t);
    wait_sig(0, 1'b1, 3000, t);
    check(status_n == 1'b0, "R7 blank image fails at end", status_n, 0);
    wait_sig(2, 1'b1, 200, t);
    check(t < 0 && retry_cnt >= 1, "R7 no user mode on blank", user_mode, 0);
    cfg_req_n = 1'b0;
    blank = 1'b0;

    // R8: retry counter saturates
    do_reset();
    done_mode = 2;
    cfg_req_n = 1'b1;
    for (int i = 0; i < (1 << RW) + 2; i++) begin
      wait_sig(1, 1'b0, 3000, t);
      wait_sig(1, 1'b1, 100, w);
    end
    check(retry_cnt == {RW{1'b1}}, "R8 retry saturation", retry_cnt, {RW{1'b1}});
    check(!user_mode, "R8 no user mode while failing", user_mode, 0);
    cfg_req_n = 1'b0;
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
    end
  end

endmodule